// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. In a single combinational pass it produces a result word and four status flags. The operations are addition, subtraction, comparison, bitwise AND, OR, XOR and NOT, and three shifts: logical left, logical right and arithmetic right. An operand-select input takes the second operand either from a register input or from a 16-bit immediate. Arithmetic operations sign-extend the immediate. Bitwise operations zero-extend it. A write-enable output tells the surrounding datapath whether the result should be stored.

A small condition evaluator sits beside the ALU. It takes a packed four-bit flag word and a four-bit condition code, and it reports whether the condition holds. A branch unit or a set-on-condition instruction uses it. It has its own flag input, so the caller can feed it flags held in a status register rather than the flags being computed in the same cycle.

The flag rules are exact and follow these points:
- The shift count uses only its low five bits.
- A shift by zero clears carry.
- Logic and shift operations always clear overflow.
- Bitwise operations leave the incoming carry unchanged.

Top module: `int_alu_flags`

## Requirements
- R1: Opcode encoding on `op_i`: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 NOT (inverts the second operand), 7 shift left, 8 shift right logical, 9 shift right arithmetic. Codes 10 to 15 are reserved. For a reserved code, result, write enable and all four flags are zero.
- R2: Flag word layout is zero in bit 0, sign in bit 1, overflow in bit 2 and carry in bit 3. For every defined opcode, zero is set exactly when all 32 result bits are 0, and sign equals result bit 31.
- R3: Add returns the 32-bit sum of `reg_a_i` and the second operand. Carry is the unsigned carry-out. Overflow is set when the signed sum does not fit in 32 bits. The incoming carry is not added.
- R4: Subtract returns `reg_a_i` minus the second operand. Carry is set on an unsigned borrow (first operand below second). Overflow is set when the signed difference does not fit.
- R5: Compare drives the same result and flags as subtract but holds `write_en_o` low. Every other defined opcode drives `write_en_o` high.
- R6: With `use_imm_i` high, add, subtract and compare sign-extend `imm_i`, while AND, OR, XOR and NOT zero-extend it. For example, AND of all ones with immediate 0xFFFF gives 0x0000FFFF with sign clear.
- R7: AND, OR, XOR and NOT clear overflow and pass `carry_i` unchanged to the carry flag.
- R8: The shift count is bits 4:0 of the second operand and all higher bits are ignored. A count of all ones acts as 31, so 6 shifted left by -1 gives 0 with carry set.
- R9: A shift by a count of zero returns `reg_a_i` unchanged and clears carry.
- R10: On a nonzero shift, carry is the last bit shifted out and overflow is clear. Shift right arithmetic fills with the sign bit. The other two shifts fill with zeros.
- R11: Condition codes 0 to 7 test, in order: overflow; carry; zero; carry OR zero; sign; always true; sign XOR overflow; (sign XOR overflow) OR zero.
- R12: Bit 3 of the condition code inverts the base condition, so codes 8 to 15 are the complements of codes 0 to 7 (code 13 is never true, code 11 is carry and zero both clear).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Selects the immediate as second operand |
| reg_a_i | input | 32 | First operand, and the value that is shifted |
| reg_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate operand |
| carry_i | input | 1 | Current carry, passed through by bitwise operations |
| result_o | output | 32 | Operation result |
| write_en_o | output | 1 | Result should be stored |
| flags_o | output | 4 | Packed flags {carry, overflow, sign, zero} |
| cond_code_i | input | 4 | Condition code to evaluate |
| cond_flags_i | input | 4 | Flag word tested by the evaluator |
| cond_taken_o | output | 1 | Condition holds |

## Verification
Embedded assertions check the following whenever the inputs are known:
- The adder's carry and borrow against a widened unsigned sum.
- Its overflow against a widened signed sum.
- The zero-count shift identity.
- The carry bit shifted out on nonzero counts.
- That compare never enables a write.
- That bitwise and shift operations clear overflow.
- That reserved opcodes stay quiet.
- The fixed always and never condition codes.

Other behaviours can only be shown by the bench's scenarios:
- Immediate extension by operation class.
- Masking of the shift count.
- Pass-through of the incoming carry.
- The full condition table, checked over all 256 code and flag pairs.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_CMP = 4'd2,
      OP_AND = 4'd3,
      OP_OR  = 4'd4,
      OP_XOR = 4'd5,
      OP_NOT = 4'd6,
      OP_SHL = 4'd7,
      OP_SHR = 4'd8,
      OP_SAR = 4'd9
   } alu_op_e;

   localparam int FLAG_Z = 0;
   localparam int FLAG_S = 1;
   localparam int FLAG_V = 2;
   localparam int FLAG_C = 3;

   typedef enum logic [1:0] {
      BW_AND = 2'd0,
      BW_OR  = 2'd1,
      BW_XOR = 2'd2,
      BW_NOT = 2'd3
   } bitwise_fn_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         carry_o,
   output logic         ovf_o
);

   logic [W-1:0] b_eff;
   logic         cout;

   always_comb begin
      b_eff            = sub_i ? ~b_i : b_i;
      {cout, sum_o}    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
      // borrow is the inverted carry-out of a + ~b + 1
      carry_o          = cout ^ sub_i;
      ovf_o            = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
   end

   logic signed [W:0] wide_s;
   logic        [W:0] wide_u;

   always_comb begin
      wide_s = sub_i ? ($signed({a_i[W-1], a_i}) - $signed({b_i[W-1], b_i}))
                     : ($signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i}));
      wide_u = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
      if (!$isunknown({a_i, b_i, sub_i})) begin
         // R3 and R4: signed range check
         a_r3_overflow: assert (ovf_o == (wide_s[W] != wide_s[W-1]))
            else $error("overflow flag disagrees with widened signed sum");
         a_r4_borrow: assert (carry_o == wide_u[W])
            else $error("carry/borrow disagrees with widened unsigned sum");
      end
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
   import alu_flags_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  bitwise_fn_e  fn_i,
   output logic [W-1:0] res_o
);

   always_comb begin
      unique case (fn_i)
         BW_AND:  res_o = a_i & b_i;
         BW_OR:   res_o = a_i | b_i;
         BW_XOR:  res_o = a_i ^ b_i;
         default: res_o = ~b_i;
      endcase
   end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int W      = 32,
   parameter bit STAGED = 1'b1,
   localparam int CW    = $clog2(W)
) (
   input  logic [W-1:0]  a_i,
   input  logic [CW-1:0] cnt_i,
   input  logic          left_i,
   input  logic          arith_i,
   output logic [W-1:0]  res_o,
   output logic          carry_o
);

   // both vectors carry one extra bit that catches the last bit shifted out
   logic [W:0] lsh;
   logic [W:0] rsh;
   logic       fill;

   assign fill = arith_i & a_i[W-1];

   generate
      if (STAGED) begin : g_staged
         logic [W:0] lstg [CW+1];
         logic [W:0] rstg [CW+1];
         assign lstg[0] = {1'b0, a_i};
         assign rstg[0] = {a_i, 1'b0};
         for (genvar k = 0; k < CW; k++) begin : g_stage
            localparam int S = 1 << k;
            assign lstg[k+1] = cnt_i[k] ? (lstg[k] << S) : lstg[k];
            assign rstg[k+1] = cnt_i[k] ? {{S{fill}}, rstg[k][W:S]} : rstg[k];
         end
         assign lsh = lstg[CW];
         assign rsh = rstg[CW];
      end else begin : g_behav
         logic [2*W+1:0] rext;
         assign lsh  = {1'b0, a_i} << cnt_i;
         assign rext = {{(W+1){fill}}, a_i, 1'b0} >> cnt_i;
         assign rsh  = rext[W:0];
      end
   endgenerate

   always_comb begin
      if (left_i) {carry_o, res_o} = lsh;
      else        {res_o, carry_o} = rsh;
   end

   always_comb begin
      if (!$isunknown({a_i, cnt_i, left_i, arith_i})) begin
         if (cnt_i == '0) begin
            a_r9_zero_shift: assert (res_o == a_i && !carry_o)
               else $error("zero-count shift altered value or carry");
         end else if (left_i) begin
            a_r10_left_carry: assert (carry_o == a_i[W - int'(cnt_i)])
               else $error("left shift carry is not last bit out");
         end else begin
            a_r10_right_carry: assert (carry_o == a_i[int'(cnt_i) - 1])
               else $error("right shift carry is not last bit out");
         end
      end
   end

endmodule

// File: rtl/alu_cond_eval.sv
module alu_cond_eval
   import alu_flags_pkg::*;
(
   input  logic [3:0] flags_i,
   input  logic [3:0] code_i,
   output logic       taken_o
);

   logic z, s, v, c, base;

   always_comb begin
      z = flags_i[FLAG_Z];
      s = flags_i[FLAG_S];
      v = flags_i[FLAG_V];
      c = flags_i[FLAG_C];
      unique case (code_i[2:0])
         3'd0: base = v;
         3'd1: base = c;
         3'd2: base = z;
         3'd3: base = c | z;
         3'd4: base = s;
         3'd5: base = 1'b1;
         3'd6: base = s ^ v;
         default: base = (s ^ v) | z;
      endcase
      taken_o = base ^ code_i[3];
   end

   always_comb begin
      if (!$isunknown({flags_i, code_i})) begin
         if (code_i == 4'd5) begin
            a_r11_always: assert (taken_o) else $error("always code not taken");
         end
         if (code_i == 4'd13) begin
            a_r12_never: assert (!taken_o) else $error("never code taken");
         end
      end
   end

endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
   import alu_flags_pkg::*;
#(
   parameter int W        = 32,
   parameter int IMM_W    = 16,
   parameter bit STAGED   = 1'b1,
   localparam int CW      = $clog2(W)
) (
   input  logic [3:0]       op_i,
   input  logic             use_imm_i,
   input  logic [W-1:0]     reg_a_i,
   input  logic [W-1:0]     reg_b_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic             carry_i,
   output logic [W-1:0]     result_o,
   output logic             write_en_o,
   output logic [3:0]       flags_o,
   input  logic [3:0]       cond_code_i,
   input  logic [3:0]       cond_flags_i,
   output logic             cond_taken_o
);

   generate
      if ((1 << CW) != W) begin : g_bad_width
         $error("W must be a power of two");
      end
      if (IMM_W >= W || IMM_W < 1) begin : g_bad_imm
         $error("IMM_W must be between 1 and W-1");
      end
   endgenerate

   alu_op_e      op;
   logic         is_bitwise, is_shift, is_arith, defined;
   logic [W-1:0] imm_sx, imm_zx, opnd_b;

   assign op = alu_op_e'(op_i);

   always_comb begin
      is_arith   = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
      is_bitwise = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
      is_shift   = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
      defined    = is_arith || is_bitwise || is_shift;
      imm_sx     = {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
      imm_zx     = {{(W-IMM_W){1'b0}}, imm_i};
      opnd_b     = use_imm_i ? (is_bitwise ? imm_zx : imm_sx) : reg_b_i;
   end

   logic [W-1:0] sum, bw_res, sh_res;
   logic         add_c, add_v, sh_c;
   bitwise_fn_e  bw_fn;

   alu_addsub #(.W(W)) u_addsub (
      .a_i     (reg_a_i),
      .b_i     (opnd_b),
      .sub_i   (op != OP_ADD),
      .sum_o   (sum),
      .carry_o (add_c),
      .ovf_o   (add_v)
   );

   always_comb begin
      unique case (op)
         OP_AND:  bw_fn = BW_AND;
         OP_OR:   bw_fn = BW_OR;
         OP_XOR:  bw_fn = BW_XOR;
         default: bw_fn = BW_NOT;
      endcase
   end

   alu_bitwise #(.W(W)) u_bitwise (
      .a_i   (reg_a_i),
      .b_i   (opnd_b),
      .fn_i  (bw_fn),
      .res_o (bw_res)
   );

   alu_shifter #(.W(W), .STAGED(STAGED)) u_shifter (
      .a_i     (reg_a_i),
      .cnt_i   (opnd_b[CW-1:0]),
      .left_i  (op == OP_SHL),
      .arith_i (op == OP_SAR),
      .res_o   (sh_res),
      .carry_o (sh_c)
   );

   logic c_flag, v_flag;

   always_comb begin
      result_o   = '0;
      c_flag     = 1'b0;
      v_flag     = 1'b0;
      write_en_o = defined && (op != OP_CMP);
      if (is_arith) begin
         result_o = sum;
         c_flag   = add_c;
         v_flag   = add_v;
      end else if (is_bitwise) begin
         result_o = bw_res;
         c_flag   = carry_i;
      end else if (is_shift) begin
         result_o = sh_res;
         c_flag   = sh_c;
      end
      flags_o          = '0;
      flags_o[FLAG_Z]  = defined && (result_o == '0);
      flags_o[FLAG_S]  = defined && result_o[W-1];
      flags_o[FLAG_V]  = v_flag;
      flags_o[FLAG_C]  = c_flag;
   end

   alu_cond_eval u_cond (
      .flags_i (cond_flags_i),
      .code_i  (cond_code_i),
      .taken_o (cond_taken_o)
   );

   always_comb begin
      if (!$isunknown({op_i, use_imm_i, reg_a_i, reg_b_i, imm_i, carry_i})) begin
         if (op_i == 4'd2) begin
            a_r5_cmp_no_write: assert (!write_en_o)
               else $error("compare enabled a write");
         end
         if (op_i >= 4'd3 && op_i <= 4'd9) begin
            a_r7_no_overflow: assert (!flags_o[FLAG_V])
               else $error("bitwise/shift op set overflow");
         end
         if (op_i >= 4'd10) begin
            a_r1_reserved_quiet: assert (result_o == '0 && flags_o == 4'd0 && !write_en_o)
               else $error("reserved opcode produced activity");
         end
      end
   end

endmodule

// File: tb/int_alu_flags_bench.sv
`timescale 1ns/1ps
module int_alu_flags_bench;

   logic        clk = 1'b0;
   always #2 clk = ~clk;

   logic [3:0]  op;
   logic        use_imm;
   logic [31:0] ra, rb;
   logic [15:0] imm;
   logic        cin;
   logic [31:0] res;
   logic        we;
   logic [3:0]  fl;
   logic [3:0]  ccode, cflags;
   logic        ctaken;

   int_alu_flags u_int_alu_flags (
      .op_i         (op),
      .use_imm_i    (use_imm),
      .reg_a_i      (ra),
      .reg_b_i      (rb),
      .imm_i        (imm),
      .carry_i      (cin),
      .result_o     (res),
      .write_en_o   (we),
      .flags_o      (fl),
      .cond_code_i  (ccode),
      .cond_flags_i (cflags),
      .cond_taken_o (ctaken)
   );

   typedef struct packed {
      logic [3:0]  op;
      logic        ui;
      logic [31:0] a;
      logic [31:0] b;
      logic [15:0] imm;
      logic        ci;
      logic [31:0] res;
      logic [3:0]  fl;   // {C,V,S,Z}
      logic        we;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 38;
   localparam vec_t VEC [NV] = '{
      // R3 add forms, incoming carry must not be added
      '{4'd0, 1'b0, 32'h2,        32'h3,        16'h0,    1'b1, 32'h5,        4'b0000, 1'b1, 8'd3},
      '{4'd0, 1'b0, 32'h2,        32'hFFFFFFFE, 16'h0,    1'b0, 32'h0,        4'b1001, 1'b1, 8'd3},
      '{4'd0, 1'b0, 32'h2,        32'hFFFFFFFD, 16'h0,    1'b0, 32'hFFFFFFFF, 4'b0010, 1'b1, 8'd3},
      '{4'd0, 1'b0, 32'hFFFFFFFF, 32'h2,        16'h0,    1'b0, 32'h1,        4'b1000, 1'b1, 8'd3},
      '{4'd0, 1'b0, 32'h7FFFFFFF, 32'h1,        16'h0,    1'b0, 32'h80000000, 4'b0110, 1'b1, 8'd3},
      // R6 add immediate sign-extended
      '{4'd0, 1'b1, 32'h2,        32'h0,        16'hFFFE, 1'b0, 32'h0,        4'b1001, 1'b1, 8'd6},
      // R4 subtract
      '{4'd1, 1'b0, 32'h3,        32'h2,        16'h0,    1'b1, 32'h1,        4'b0000, 1'b1, 8'd4},
      '{4'd1, 1'b0, 32'h2,        32'h2,        16'h0,    1'b0, 32'h0,        4'b0001, 1'b1, 8'd4},
      '{4'd1, 1'b0, 32'h2,        32'h3,        16'h0,    1'b0, 32'hFFFFFFFF, 4'b1010, 1'b1, 8'd4},
      '{4'd1, 1'b0, 32'hFFFFFFFF, 32'h2,        16'h0,    1'b0, 32'hFFFFFFFD, 4'b0010, 1'b1, 8'd4},
      '{4'd1, 1'b0, 32'h80000000, 32'h1,        16'h0,    1'b0, 32'h7FFFFFFF, 4'b0100, 1'b1, 8'd4},
      // R5 compare: flags as subtract, no write
      '{4'd2, 1'b0, 32'hA,        32'hA,        16'h0,    1'b0, 32'h0,        4'b0001, 1'b0, 8'd5},
      '{4'd2, 1'b1, 32'hA,        32'h0,        16'h000B, 1'b0, 32'hFFFFFFFF, 4'b1010, 1'b0, 8'd5},
      '{4'd2, 1'b1, 32'h0,        32'h0,        16'hFFFF, 1'b0, 32'h1,        4'b1000, 1'b0, 8'd6},
      // R7 bitwise, carry passes through
      '{4'd3, 1'b0, 32'h3,        32'h9,        16'h0,    1'b1, 32'h1,        4'b1000, 1'b1, 8'd7},
      '{4'd4, 1'b0, 32'h3,        32'h9,        16'h0,    1'b0, 32'hB,        4'b0000, 1'b1, 8'd7},
      '{4'd5, 1'b0, 32'hF,        32'hA,        16'h0,    1'b0, 32'h5,        4'b0000, 1'b1, 8'd7},
      '{4'd6, 1'b0, 32'h0,        32'hAAAAAAAA, 16'h0,    1'b0, 32'h55555555, 4'b0000, 1'b1, 8'd7},
      '{4'd6, 1'b0, 32'h0,        32'h55555555, 16'h0,    1'b1, 32'hAAAAAAAA, 4'b1010, 1'b1, 8'd7},
      '{4'd6, 1'b0, 32'h0,        32'hFFFFFFFF, 16'h0,    1'b1, 32'h0,        4'b1001, 1'b1, 8'd7},
      // R6 bitwise immediates zero-extended
      '{4'd3, 1'b1, 32'hFFFFFFFF, 32'h0,        16'hFFFF, 1'b0, 32'h0000FFFF, 4'b0000, 1'b1, 8'd6},
      '{4'd5, 1'b1, 32'h0,        32'h0,        16'hFFFF, 1'b0, 32'h0000FFFF, 4'b0000, 1'b1, 8'd6},
      '{4'd4, 1'b1, 32'h0,        32'h0,        16'h8000, 1'b0, 32'h00008000, 4'b0000, 1'b1, 8'd6},
      // R9 zero shifts clear carry
      '{4'd7, 1'b0, 32'hFFFFFFFF, 32'h0,        16'h0,    1'b1, 32'hFFFFFFFF, 4'b0010, 1'b1, 8'd9},
      '{4'd9, 1'b1, 32'h7,        32'h0,        16'h0000, 1'b1, 32'h7,        4'b0000, 1'b1, 8'd9},
      // R10 shifts, last bit out
      '{4'd7, 1'b0, 32'hBFFFFFFF, 32'h1,        16'h0,    1'b0, 32'h7FFFFFFE, 4'b1000, 1'b1, 8'd10},
      '{4'd7, 1'b0, 32'h6,        32'h1,        16'h0,    1'b0, 32'hC,        4'b0000, 1'b1, 8'd10},
      '{4'd7, 1'b0, 32'hFFFFFFFA, 32'h1,        16'h0,    1'b0, 32'hFFFFFFF4, 4'b1010, 1'b1, 8'd10},
      '{4'd7, 1'b0, 32'h8,        32'd29,       16'h0,    1'b0, 32'h0,        4'b1001, 1'b1, 8'd10},
      '{4'd8, 1'b0, 32'h7,        32'h1,        16'h0,    1'b0, 32'h3,        4'b1000, 1'b1, 8'd10},
      '{4'd8, 1'b0, 32'hFFFFFFFA, 32'h1,        16'h0,    1'b0, 32'h7FFFFFFD, 4'b0000, 1'b1, 8'd10},
      '{4'd8, 1'b0, 32'h6,        32'h3,        16'h0,    1'b0, 32'h0,        4'b1001, 1'b1, 8'd10},
      '{4'd9, 1'b0, 32'hFFFFFFFA, 32'h1,        16'h0,    1'b0, 32'hFFFFFFFD, 4'b0010, 1'b1, 8'd10},
      // R8 count masked to five bits
      '{4'd7, 1'b0, 32'h6,        32'hFFFFFFFF, 16'h0,    1'b0, 32'h0,        4'b1001, 1'b1, 8'd8},
      '{4'd8, 1'b0, 32'hFFFFFFFA, 32'hFFFFFFFF, 16'h0,    1'b0, 32'h1,        4'b1000, 1'b1, 8'd8},
      '{4'd9, 1'b0, 32'hFFFFFFFA, 32'hFFFFFFFF, 16'h0,    1'b0, 32'hFFFFFFFF, 4'b1010, 1'b1, 8'd8},
      '{4'd8, 1'b0, 32'h7,        32'h20,       16'h0,    1'b1, 32'h7,        4'b0000, 1'b1, 8'd8},
      '{4'd7, 1'b1, 32'h6,        32'h0,        16'h0021, 1'b0, 32'hC,        4'b0000, 1'b1, 8'd8}
   };

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   function automatic logic cond_model(input logic [3:0] f, input logic [3:0] c);
      logic z, s, v, cy, b;
      z = f[0]; s = f[1]; v = f[2]; cy = f[3];
      case (c[2:0])
         3'd0: b = v;
         3'd1: b = cy;
         3'd2: b = z;
         3'd3: b = cy | z;
         3'd4: b = s;
         3'd5: b = 1'b1;
         3'd6: b = s ^ v;
         default: b = (s ^ v) | z;
      endcase
      return c[3] ? ~b : b;
   endfunction

   task automatic check_alu(input string tag, input logic [31:0] er,
                            input logic [3:0] ef, input logic ew);
      checks++;
      if (res !== er || fl !== ef || we !== ew) begin
         fails++;
         $display("FAIL %s op=%0d: result=%h flags=%b we=%b expected result=%h flags=%b we=%b",
                  tag, op, res, fl, we, er, ef, ew);
      end
   endtask

   task automatic drive(input logic [3:0] o, input logic ui, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] i, input logic c);
      @(negedge clk);
      op = o; use_imm = ui; ra = a; rb = b; imm = i; cin = c;
      #1;
   endtask

   initial begin
      op = 4'd0; use_imm = 1'b0; ra = '0; rb = '0; imm = '0; cin = 1'b0;
      ccode = 4'd0; cflags = 4'd0;
      repeat (2) @(posedge clk);

      // idle inputs: add of zeros, R2 zero flag only
      drive(4'd0, 1'b0, 32'h0, 32'h0, 16'h0, 1'b0);
      check_alu("R2 idle", 32'h0, 4'b0001, 1'b1);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].op, VEC[i].ui, VEC[i].a, VEC[i].b, VEC[i].imm, VEC[i].ci);
         check_alu($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].res, VEC[i].fl, VEC[i].we);
      end

      // R1 reserved opcodes are silent
      for (int o = 10; o < 16; o++) begin
         drive(4'(o), 1'b0, 32'h5, 32'h5, 16'h0, 1'b1);
         check_alu("R1 reserved", 32'h0, 4'b0000, 1'b0);
      end

      // R2 sign flag on a large negative sum
      drive(4'd0, 1'b0, 32'h80000000, 32'h0, 16'h0, 1'b0);
      check_alu("R2 sign", 32'h80000000, 4'b0010, 1'b1);

      // R11 / R12 full condition table
      for (int f = 0; f < 16; f++) begin
         for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            cflags = 4'(f); ccode = 4'(c);
            #1;
            checks++;
            if (ctaken !== cond_model(4'(f), 4'(c))) begin
               fails++;
               $display("FAIL %s code=%0d flags=%b: taken=%b expected %b",
                        (c < 8) ? "R11" : "R12", c, f[3:0], ctaken, cond_model(4'(f), 4'(c)));
            end
         end
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

endmodule